// File: doc/BRIEF.md
# Burst read address sequencer

This block produces the word address for a synchronous burst read from a memory with a 19-bit word address and 16-bit data. On a clock edge where the load strobe is high, the block takes in a starting address. Each later clock edge with the advance strobe high moves the five low address bits on by one, modulo 32. The upper address bits keep the loaded value, so a burst walks 32 consecutive words in linear order and wraps inside its aligned 32-word group.

An active-low end-of-burst flag marks the 32nd word counted from the loaded start address. That is the word at start plus 31, with the low bits wrapping. The flag does not mark the end of the aligned group. Chip enable and output enable are not synchronous to the clock. They gate combinationally whether the address is flagged valid, and chip enable also masks the end-of-burst flag. The sequencer keeps stepping no matter what these two pins do.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released with no strobe, `rd_addr` is 0 and `burst_end_n` is 1.
- R2: After a clock edge with `burst_load` high, `rd_addr` equals the `start_addr` sampled at that edge.
- R3: After a clock edge with `burst_adv` high and `burst_load` low, `rd_addr[4:0]` is its previous value plus 1 modulo 32 (31 is followed by 0), and `rd_addr[18:5]` is unchanged.
- R4: After a clock edge with both strobes low, `rd_addr` is unchanged.
- R5: When both strobes are high at the same edge, the load wins and `rd_addr` becomes `start_addr`, not `start_addr` plus 1.
- R6: `burst_end_n` is 0 exactly when 31 advances have been taken since the last load (the word at start plus 31) and `ce_n` is 0.
- R7: After an edge with `burst_load` or `burst_adv` high that finds `burst_end_n` at 0, `burst_end_n` is 1.
- R8: While `ce_n` is 1, `burst_end_n` is 1, at once and without a clock. The stepping state is unaffected.
- R9: `addr_valid` is 1 exactly when both `ce_n` and `oe_n` are 0. It follows these pins combinationally.
- R10: A load in the middle of a burst restarts the word count, so the end flag comes 31 advances after the new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_load | input | 1 | Capture `start_addr` at this edge |
| burst_adv | input | 1 | Step to the next word at this edge |
| start_addr | input | 19 | Starting word address of a burst |
| ce_n | input | 1 | Active-low chip enable, asynchronous to `clk` |
| oe_n | input | 1 | Active-low output enable, asynchronous to `clk` |
| rd_addr | output | 19 | Current word address |
| burst_end_n | output | 1 | Low while the 32nd word of the burst is current |
| addr_valid | output | 1 | High when the address is presented (`ce_n` and `oe_n` both low) |

## Verification
A strobe sampled at a rising edge shows its effect on `rd_addr` and on the word count one edge later, since both are registered. The bench's model therefore applies each strobe at the same posedge as the design, and outputs are compared at the following negedge. `addr_valid` and the chip-enable masking of `burst_end_n` have no register in their path. The model evaluates them from the pin levels present at that same negedge sample, so the comparison needs no delay. Stimulus is changed only right after each comparison.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
   localparam int unsigned ADDR_W_DEF  = 19;
   localparam int unsigned BURST_W_DEF = 5;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_ADV  = 2'd1,
      STEP_LOAD = 2'd2
   } step_e;
endpackage

// File: rtl/bsq_step_decode.sv
module bsq_step_decode
   import bsq_pkg::*;
(
   input  logic  load_i,
   input  logic  adv_i,
   output step_e step_o
);
   // load outranks advance
   always_comb begin
      if (load_i)     step_o = STEP_LOAD;
      else if (adv_i) step_o = STEP_ADV;
      else            step_o = STEP_HOLD;
   end
endmodule

// File: rtl/bsq_wrap_counter.sv
module bsq_wrap_counter
   import bsq_pkg::*;
#(
   parameter int unsigned W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  step_e        step_i,
   input  logic [W-1:0] seed_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_o <= '0;
      end else begin
         unique case (step_i)
            STEP_LOAD: q_o <= seed_i;
            STEP_ADV:  q_o <= q_o + W'(1);
            default:   q_o <= q_o;
         endcase
      end
   end
endmodule

// File: rtl/bsq_span_tracker.sv
module bsq_span_tracker
   import bsq_pkg::*;
#(
   parameter int unsigned W = 5
) (
   input  logic  clk,
   input  logic  rst_n,
   input  step_e step_i,
   output logic  last_o
);
   logic [W-1:0] taken_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taken_q <= '0;
      end else begin
         unique case (step_i)
            STEP_LOAD: taken_q <= '0;
            STEP_ADV:  taken_q <= taken_q + W'(1);
            default:   taken_q <= taken_q;
         endcase
      end
   end

   assign last_o = &taken_q;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bsq_pkg::*;
#(
   parameter int unsigned ADDR_W  = ADDR_W_DEF,
   parameter int unsigned BURST_W = BURST_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              burst_load,
   input  logic              burst_adv,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              ce_n,
   input  logic              oe_n,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              burst_end_n,
   output logic              addr_valid
);
   localparam int unsigned UPPER_W = ADDR_W - BURST_W;

   if (BURST_W < 1 || BURST_W > ADDR_W) begin : g_bad_widths
      $error("burst_addr_seq: BURST_W must lie in 1..ADDR_W");
   end

   step_e              step;
   logic [BURST_W-1:0] low_q;
   logic               span_last;

   bsq_step_decode u_dec (
      .load_i (burst_load),
      .adv_i  (burst_adv),
      .step_o (step)
   );

   bsq_wrap_counter #(.W(BURST_W)) u_low (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step),
      .seed_i (start_addr[BURST_W-1:0]),
      .q_o    (low_q)
   );

   bsq_span_tracker #(.W(BURST_W)) u_span (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step),
      .last_o (span_last)
   );

   if (UPPER_W > 0) begin : g_upper
      logic [UPPER_W-1:0] upper_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                upper_q <= '0;
         else if (step == STEP_LOAD) upper_q <= start_addr[ADDR_W-1:BURST_W];
      end
      assign rd_addr = {upper_q, low_q};
   end else begin : g_no_upper
      assign rd_addr = low_q;
   end

   // asynchronous enables only gate the flags
   assign addr_valid  = ~ce_n & ~oe_n;
   assign burst_end_n = ~(span_last & ~ce_n);
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
   parameter int unsigned ADDR_W  = 19,
   parameter int unsigned BURST_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              burst_load,
   input logic              burst_adv,
   input logic [ADDR_W-1:0] start_addr,
   input logic              ce_n,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              burst_end_n
);
   AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      burst_load |=> rd_addr == $past(start_addr)); // R2

   AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_adv && !burst_load) |=>
         rd_addr[BURST_W-1:0] == BURST_W'($past(rd_addr[BURST_W-1:0]) + 1)); // R3

   if (ADDR_W > BURST_W) begin : g_upper_chk
      AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         !burst_load |=> $stable(rd_addr[ADDR_W-1:BURST_W])); // R3
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!burst_load && !burst_adv) |=> $stable(rd_addr)); // R4

   AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!burst_end_n && (burst_load || burst_adv)) |=> burst_end_n); // R7

   AST_CE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> burst_end_n); // R8

   AST_RELOAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      burst_load |=> burst_end_n); // R10
endmodule

bind burst_addr_seq bsq_checker #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .burst_load  (burst_load),
   .burst_adv   (burst_adv),
   .start_addr  (start_addr),
   .ce_n        (ce_n),
   .rd_addr     (rd_addr),
   .burst_end_n (burst_end_n)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        burst_load = 1'b0;
   logic        burst_adv = 1'b0;
   logic [18:0] start_addr = '0;
   logic        ce_n = 1'b0;
   logic        oe_n = 1'b0;
   logic [18:0] rd_addr;
   logic        burst_end_n;
   logic        addr_valid;

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    finished = 1'b0;
   string cur_tag  = "R1";

   // behavioural reference state
   int m_addr  = 0;
   int m_taken = 0;

   always #10 clk = ~clk;

   burst_addr_seq u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .burst_load  (burst_load),
      .burst_adv   (burst_adv),
      .start_addr  (start_addr),
      .ce_n        (ce_n),
      .oe_n        (oe_n),
      .rd_addr     (rd_addr),
      .burst_end_n (burst_end_n),
      .addr_valid  (addr_valid)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_addr  = 0;
         m_taken = 0;
      end else if (burst_load) begin
         m_addr  = int'(start_addr);
         m_taken = 0;
      end else if (burst_adv) begin
         m_addr  = (m_addr / 32) * 32 + ((m_addr % 32) + 1) % 32;
         m_taken = (m_taken + 1) % 32;
      end
   end

   task automatic compare_outputs();
      int exp_end;
      int exp_val;
      exp_end = (m_taken == 31 && ce_n == 1'b0) ? 0 : 1;
      exp_val = (ce_n == 1'b0 && oe_n == 1'b0) ? 1 : 0;
      n_checks++;
      if (int'(rd_addr) != m_addr) begin
         n_fails++;
         $display("FAIL %s rd_addr actual=%05h expected=%05h", cur_tag, rd_addr, m_addr);
      end
      n_checks++;
      if (int'(burst_end_n) != exp_end) begin
         n_fails++;
         $display("FAIL %s burst_end_n actual=%0d expected=%0d", cur_tag, burst_end_n, exp_end);
      end
      n_checks++;
      if (int'(addr_valid) != exp_val) begin
         n_fails++;
         $display("FAIL %s addr_valid actual=%0d expected=%0d", cur_tag, addr_valid, exp_val);
      end
   endtask

   // compare at the negedge, then apply the next stimulus
   task automatic step(input logic ld, input logic adv, input logic [18:0] sa,
                       input logic ce, input logic oe, input string tag);
      @(negedge clk);
      compare_outputs();
      burst_load = ld;
      burst_adv  = adv;
      start_addr = sa;
      ce_n       = ce;
      oe_n       = oe;
      cur_tag    = tag;
   endtask

   task automatic run_adv(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 1'b1, 19'h0, 1'b0, 1'b0, tag);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      // R1: reset state
      cur_tag = "R1";
      repeat (3) @(negedge clk);
      compare_outputs();
      rst_n = 1'b1;
      step(1'b0, 1'b0, 19'h0, 1'b0, 1'b0, "R1");
      step(1'b0, 1'b0, 19'h0, 1'b0, 1'b0, "R1");

      // R9: enable combinations
      step(1'b0, 1'b0, 19'h0, 1'b1, 1'b0, "R9");
      step(1'b0, 1'b0, 19'h0, 1'b0, 1'b1, "R9");
      step(1'b0, 1'b0, 19'h0, 1'b1, 1'b1, "R9");
      step(1'b0, 1'b0, 19'h0, 1'b0, 1'b0, "R9");

      // R2: loads
      step(1'b1, 1'b0, 19'h12345, 1'b0, 1'b0, "R2");
      step(1'b1, 1'b0, 19'h7FFFF, 1'b0, 1'b0, "R2");
      step(1'b0, 1'b0, 19'h0, 1'b0, 1'b0, "R2");

      // R3: stepping across the low-bit wrap
      step(1'b1, 1'b0, 19'h0A01E, 1'b0, 1'b0, "R3");
      run_adv(40, "R3");

      // R4: idle holds
      step(1'b0, 1'b0, 19'h55555, 1'b0, 1'b0, "R4");
      step(1'b0, 1'b0, 19'h2AAAA, 1'b0, 1'b0, "R4");
      step(1'b0, 1'b0, 19'h0, 1'b0, 1'b0, "R4");

      // R5: load and advance together
      step(1'b1, 1'b1, 19'h00100, 1'b0, 1'b0, "R5");
      step(1'b0, 1'b0, 19'h0, 1'b0, 1'b0, "R5");

      // R6: full burst from an unaligned start
      step(1'b1, 1'b0, 19'h23457, 1'b0, 1'b0, "R6");
      run_adv(31, "R6");
      step(1'b0, 1'b0, 19'h0, 1'b0, 1'b0, "R6");

      // R7: release by advance, then by load
      step(1'b0, 1'b1, 19'h0, 1'b0, 1'b0, "R7");
      run_adv(31, "R7");
      step(1'b1, 1'b0, 19'h40000, 1'b0, 1'b0, "R7");
      step(1'b0, 1'b0, 19'h0, 1'b0, 1'b0, "R7");

      // R8: chip enable masks the flag
      run_adv(31, "R8");
      step(1'b0, 1'b0, 19'h0, 1'b1, 1'b0, "R8");
      step(1'b0, 1'b0, 19'h0, 1'b1, 1'b1, "R8");
      step(1'b0, 1'b0, 19'h0, 1'b0, 1'b0, "R8");
      step(1'b0, 1'b0, 19'h0, 1'b0, 1'b0, "R8");

      // R10: reload mid-burst
      step(1'b1, 1'b0, 19'h01010, 1'b0, 1'b0, "R10");
      run_adv(10, "R10");
      step(1'b1, 1'b0, 19'h3FFF3, 1'b0, 1'b0, "R10");
      run_adv(31, "R10");
      step(1'b0, 1'b0, 19'h0, 1'b0, 1'b0, "R10");
      step(1'b0, 1'b0, 19'h0, 1'b0, 1'b0, "R10");
      @(negedge clk);
      compare_outputs();

      finished = 1'b1;
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=running expected=done");
         report();
      end
   end
endmodule